// File: doc/BRIEF.md
# Self-Programming Flash Row Controller

This block sits between a processor and a program flash made of 24-bit instruction words grouped into rows. Software stages one row of data through a table-write port. Each instruction arrives as a 16-bit low word followed by an 8-bit high part, and both land in a row-wide staging buffer. Every table write also records its 24-bit effective address in an address register, which software can also write directly. An operation is launched from a control register, but only after a two-step key has been written to a write-only key register.

Once launched, the block drives the flash array. A row erase is a single command pulse. A row program first streams every column of the staging buffer to the array and then issues a program pulse. Columns that software never loaded are sent as all ones, so the array leaves them erased. The array ends either operation with a done pulse, after which the busy bit clears by itself. A completed program also empties the staging buffer.

Top module: `nvm_prog_ctrl`

## Requirements
- R1: Reset state. After a synchronous reset, `busy` and `err` are 0, the address register is 0, the staging buffer is empty, and no array command is active. `rd_data` reads 0 with `reg_sel`=0.
- R2: Unlock key. An operation may launch only after register 3 receives low byte 0x55 and then, in the very next register or table write, low byte 0xAA. Any other write in between, or any other value, cancels the sequence. One launch uses up the unlock.
- R3: Start without unlock. A start (CTRL bit0=1) with no valid unlock issues no array command and leaves `busy` at 0. It sets the sticky `err` flag. Writing CTRL with bit2=1 while idle clears `err`, and a new error in the same write takes priority over the clear.
- R4: Address register. Every table write loads `tw_addr` into the address register. A write to register 1 sets bits 15:0 and a write to register 2 sets bits 23:16 from data bits 7:0. Reads of registers 1 and 2 return these fields, zero-extended.
- R5: Staging order. A low write (`tw_hi`=0) must target column = fill count, in the row of the pending data. When the buffer is empty the column must be 0, and that write selects the row. A high write must follow a pending low write at the same address. It stores {data[7:0], low word} and advances the fill count. Any write that breaks these rules, or arrives when the buffer is full, sets `err` and stores nothing.
- R6: A table write while `busy` sets `err` and changes no staged data.
- R7: Erase. Start with CTRL bit1=0 produces one `arr_erase` pulse with `arr_row` = address bits 23:log2(ROW_WORDS). `busy` stays 1 until `arr_done`.
- R8: Program. Start with bit1=1 streams one `arr_wr` word per cycle for columns 0 to ROW_WORDS-1 in order. Loaded columns carry staged data and the rest carry all ones. One `arr_prog` pulse follows the last column. After `arr_done` the buffer is empty.
- R9: Reading register 0 returns bit0 busy, bit1 selected operation, bit2 err and bit3 buffer full. `rd_data` shows the register chosen by `reg_sel` one cycle later. Register 3 reads 0.
- R10: Control writes while `busy` have no effect and do not use up an unlock. Key writes still advance the key state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address low, 2 address high, 3 key |
| reg_wdata | input | BUS_W | Register write data |
| rd_data | output | BUS_W | Registered read data of the selected register |
| tw_en | input | 1 | Table write strobe |
| tw_hi | input | 1 | 0 = low word, 1 = high part |
| tw_addr | input | ADDR_W | Table write effective address, in instruction units |
| tw_data | input | BUS_W | Table write data |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Sticky error flag |
| arr_erase | output | 1 | Row erase command pulse |
| arr_prog | output | 1 | Row program command pulse |
| arr_row | output | ADDR_W-log2(ROW_WORDS) | Target row |
| arr_wr | output | 1 | Stream word valid |
| arr_col | output | log2(ROW_WORDS) | Stream column |
| arr_wdata | output | WORD_W | Stream word |
| arr_done | input | 1 | Array operation finished |

## Verification
The bench builds the block with ROW_WORDS=8 and leaves the other parameters at their defaults. The short row means a full row, an overrun write, and a partial row padded with ones all occur within a few dozen cycles. The same programmed data can then be compared word by word against a behavioural array that answers three cycles after each command. This size keeps the whole address, column and unlock logic in play, while the stream length and array latency stay small enough that busy-window cases fit into a short run. Those cases are a table write during an operation, a control write during an operation, and a key sequence entered while busy.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
  typedef enum logic [1:0] {K_LOCKED, K_HALF, K_OPEN} key_st_e;
  typedef enum logic [2:0] {S_IDLE, S_STREAM, S_FLUSH, S_GO, S_WAIT} seq_st_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADRL = 2'd1;
  localparam logic [1:0] SEL_ADRU = 2'd2;
  localparam logic [1:0] SEL_KEY  = 2'd3;

  localparam int CB_START = 0;
  localparam int CB_OP    = 1;
  localparam int CB_ERR   = 2;
  localparam int CB_FULL  = 3;
endpackage

// File: rtl/nvm_key_gate.sv
module nvm_key_gate
  import nvm_pkg::*;
#(
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       key_wr,
  input  logic [7:0] key_val,
  input  logic       other_wr,
  input  logic       consume,
  output logic       open
);
  key_st_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= K_LOCKED;
    end else if (key_wr) begin
      if (key_val == KEY_A)                       st <= K_HALF;
      else if (key_val == KEY_B && st == K_HALF)  st <= K_OPEN;
      else                                        st <= K_LOCKED;
    end else if (consume) begin
      st <= K_LOCKED;
    end else if (other_wr && st == K_HALF) begin
      st <= K_LOCKED;
    end
  end

  assign open = (st == K_OPEN);
endmodule

// File: rtl/nvm_row_latch.sv
module nvm_row_latch #(
  parameter int ROW_WORDS = 32,
  parameter int WORD_W    = 24,
  parameter int ADDR_W    = 24,
  parameter int BUS_W     = 16,
  localparam int COL_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = ADDR_W - COL_W,
  localparam int CNT_W    = $clog2(ROW_WORDS + 1),
  localparam int HI_W     = WORD_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tw_en,
  input  logic              tw_hi,
  input  logic [ADDR_W-1:0] tw_addr,
  input  logic [BUS_W-1:0]  tw_data,
  input  logic              busy,
  input  logic              clear,
  input  logic [COL_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [CNT_W-1:0]  fill,
  output logic              full,
  output logic              reject
);
  logic [WORD_W-1:0] mem [ROW_WORDS];
  logic [BUS_W-1:0]  lo_hold;
  logic              lo_pend;
  logic [ROW_W-1:0]  row_tag;

  logic [COL_W-1:0] idx;
  logic [ROW_W-1:0] row;
  logic             has_room, col_hit, row_hit, ok_lo, ok_hi, wr_ok;

  assign idx      = tw_addr[COL_W-1:0];
  assign row      = tw_addr[ADDR_W-1:COL_W];
  assign full     = (fill == CNT_W'(ROW_WORDS));
  assign has_room = !full;
  assign col_hit  = ({1'b0, idx} == fill);
  assign row_hit  = (row == row_tag);
  assign ok_lo    = has_room && col_hit && (fill == '0 || row_hit);
  assign ok_hi    = lo_pend && has_room && col_hit && row_hit;
  assign wr_ok    = tw_en && !busy && tw_hi && ok_hi;
  assign reject   = tw_en && (busy || (tw_hi ? !ok_hi : !ok_lo));

  always_ff @(posedge clk) begin
    if (rst) begin
      fill    <= '0;
      lo_pend <= 1'b0;
      lo_hold <= '0;
      row_tag <= '0;
    end else if (clear) begin
      fill    <= '0;
      lo_pend <= 1'b0;
    end else if (tw_en && !busy) begin
      if (tw_hi) begin
        if (ok_hi) begin
          fill    <= fill + CNT_W'(1);
          lo_pend <= 1'b0;
        end
      end else if (ok_lo) begin
        lo_hold <= tw_data;
        lo_pend <= 1'b1;
        row_tag <= row;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[idx] <= {tw_data[HI_W-1:0], lo_hold};
  end

  always_ff @(posedge clk) begin
    rd_word <= mem[rd_idx];
  end
endmodule

// File: rtl/nvm_op_seq.sv
module nvm_op_seq
  import nvm_pkg::*;
#(
  parameter int ROW_WORDS = 32,
  parameter int WORD_W    = 24,
  parameter int ADDR_W    = 24,
  localparam int COL_W    = $clog2(ROW_WORDS),
  localparam int ROW_W    = ADDR_W - COL_W,
  localparam int CNT_W    = $clog2(ROW_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic              op_prog,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [CNT_W-1:0]  fill,
  output logic [COL_W-1:0]  rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              done_in,
  output logic              busy,
  output logic              prog_done,
  output logic              arr_erase,
  output logic              arr_prog,
  output logic [ROW_W-1:0]  arr_row,
  output logic              arr_wr,
  output logic [COL_W-1:0]  arr_col,
  output logic [WORD_W-1:0] arr_wdata
);
  seq_st_e          st;
  logic [COL_W-1:0] rd_ptr;
  logic             v1;
  logic [COL_W-1:0] c1;
  logic             prog_q;

  assign rd_idx    = rd_ptr;
  assign busy      = (st != S_IDLE);
  assign prog_done = (st == S_WAIT) && done_in && prog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      rd_ptr    <= '0;
      v1        <= 1'b0;
      c1        <= '0;
      prog_q    <= 1'b0;
      arr_erase <= 1'b0;
      arr_prog  <= 1'b0;
      arr_row   <= '0;
      arr_wr    <= 1'b0;
      arr_col   <= '0;
      arr_wdata <= '0;
    end else begin
      arr_erase <= 1'b0;
      arr_prog  <= 1'b0;
      arr_wr    <= v1;
      arr_col   <= c1;
      arr_wdata <= ({1'b0, c1} < fill) ? rd_word : '1;
      v1        <= 1'b0;
      case (st)
        S_IDLE: if (launch) begin
          arr_row <= row_in;
          prog_q  <= op_prog;
          rd_ptr  <= '0;
          if (op_prog) st <= S_STREAM;
          else begin
            arr_erase <= 1'b1;
            st        <= S_WAIT;
          end
        end
        S_STREAM: begin
          v1 <= 1'b1;
          c1 <= rd_ptr;
          if (rd_ptr == COL_W'(ROW_WORDS - 1)) st <= S_FLUSH;
          else rd_ptr <= rd_ptr + COL_W'(1);
        end
        S_FLUSH: st <= S_GO;
        S_GO: begin
          arr_prog <= 1'b1;
          st       <= S_WAIT;
        end
        S_WAIT: if (done_in) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nvm_prog_ctrl.sv
module nvm_prog_ctrl
  import nvm_pkg::*;
#(
  parameter int ROW_WORDS     = 32,
  parameter int WORD_W        = 24,
  parameter int ADDR_W        = 24,
  parameter int BUS_W         = 16,
  parameter logic [7:0] KEY_A = 8'h55,
  parameter logic [7:0] KEY_B = 8'hAA,
  localparam int COL_W        = $clog2(ROW_WORDS),
  localparam int ROW_W        = ADDR_W - COL_W,
  localparam int CNT_W        = $clog2(ROW_WORDS + 1),
  localparam int UP_W         = ADDR_W - BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  rd_data,
  input  logic              tw_en,
  input  logic              tw_hi,
  input  logic [ADDR_W-1:0] tw_addr,
  input  logic [BUS_W-1:0]  tw_data,
  output logic              busy,
  output logic              err,
  output logic              arr_erase,
  output logic              arr_prog,
  output logic [ROW_W-1:0]  arr_row,
  output logic              arr_wr,
  output logic [COL_W-1:0]  arr_col,
  output logic [WORD_W-1:0] arr_wdata,
  input  logic              arr_done
);
  logic              key_open, ctrl_wr, start_req, launch, bad_start;
  logic              tw_reject, prog_done, full, op_q;
  logic [ADDR_W-1:0] adr_q;
  logic [CNT_W-1:0]  fill;
  logic [COL_W-1:0]  rd_idx;
  logic [WORD_W-1:0] rd_word;

  assign ctrl_wr   = reg_wr && (reg_sel == SEL_CTRL);
  assign start_req = ctrl_wr && reg_wdata[CB_START] && !busy;
  assign launch    = start_req && key_open;
  assign bad_start = start_req && !key_open;

  nvm_key_gate #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
    .clk      (clk),
    .rst      (rst),
    .key_wr   (reg_wr && reg_sel == SEL_KEY),
    .key_val  (reg_wdata[7:0]),
    .other_wr ((reg_wr && reg_sel != SEL_KEY) || tw_en),
    .consume  (launch),
    .open     (key_open)
  );

  nvm_row_latch #(.ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W),
                  .BUS_W(BUS_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .tw_en   (tw_en),
    .tw_hi   (tw_hi),
    .tw_addr (tw_addr),
    .tw_data (tw_data),
    .busy    (busy),
    .clear   (prog_done),
    .rd_idx  (rd_idx),
    .rd_word (rd_word),
    .fill    (fill),
    .full    (full),
    .reject  (tw_reject)
  );

  nvm_op_seq #(.ROW_WORDS(ROW_WORDS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .op_prog   (reg_wdata[CB_OP]),
    .row_in    (adr_q[ADDR_W-1:COL_W]),
    .fill      (fill),
    .rd_idx    (rd_idx),
    .rd_word   (rd_word),
    .done_in   (arr_done),
    .busy      (busy),
    .prog_done (prog_done),
    .arr_erase (arr_erase),
    .arr_prog  (arr_prog),
    .arr_row   (arr_row),
    .arr_wr    (arr_wr),
    .arr_col   (arr_col),
    .arr_wdata (arr_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err  <= 1'b0;
      op_q <= 1'b0;
    end else begin
      if (bad_start || tw_reject) err <= 1'b1;
      else if (ctrl_wr && !busy && reg_wdata[CB_ERR]) err <= 1'b0;
      if (ctrl_wr && !busy) op_q <= reg_wdata[CB_OP];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q <= '0;
    end else if (tw_en) begin
      adr_q <= tw_addr;
    end else if (reg_wr && reg_sel == SEL_ADRL) begin
      adr_q[BUS_W-1:0] <= reg_wdata;
    end else if (reg_wr && reg_sel == SEL_ADRU) begin
      adr_q[ADDR_W-1:BUS_W] <= reg_wdata[UP_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (reg_sel)
        SEL_CTRL: begin
          rd_data           <= '0;
          rd_data[CB_START] <= busy;
          rd_data[CB_OP]    <= op_q;
          rd_data[CB_ERR]   <= err;
          rd_data[CB_FULL]  <= full;
        end
        SEL_ADRL: rd_data <= adr_q[BUS_W-1:0];
        SEL_ADRU: rd_data <= BUS_W'(adr_q[ADDR_W-1:BUS_W]);
        default:  rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/nvm_prog_ctrl_chk.sv
module nvm_prog_ctrl_chk #(
  parameter int ROW_WORDS = 32,
  parameter int ROW_W     = 19,
  parameter int COL_W     = 5,
  parameter int BUS_W     = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             err,
  input logic             key_open,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic [BUS_W-1:0] reg_wdata,
  input logic             arr_erase,
  input logic             arr_prog,
  input logic             arr_wr,
  input logic [ROW_W-1:0] arr_row,
  input logic [COL_W-1:0] arr_col
);
  // R2: an operation only begins from the unlocked state
  p_launch_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(key_open));

  // R3: err stays set unless an idle control write clears it
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (err && !(reg_wr && reg_sel == 2'd0 && reg_wdata[2] && !busy)) |=> err);

  // R7: erase command lasts one cycle
  p_erase_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    arr_erase |=> !arr_erase);

  // R7: array commands only while busy, never both at once
  p_cmd_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (arr_erase || arr_prog || arr_wr) |-> busy);

  p_one_cmd_r7: assert property (@(posedge clk) disable iff (rst)
    !(arr_erase && arr_prog));

  // R8: row address steady through an operation
  p_row_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(arr_row));

  // R8: stream columns rise by one
  p_col_step_r8: assert property (@(posedge clk) disable iff (rst)
    (arr_wr && $past(arr_wr)) |-> (arr_col == $past(arr_col) + COL_W'(1)));

  // R8: program pulse right after the last column
  p_prog_after_stream_r8: assert property (@(posedge clk) disable iff (rst)
    arr_prog |-> ($past(arr_wr) && $past(arr_col) == COL_W'(ROW_WORDS - 1)));
endmodule

bind nvm_prog_ctrl nvm_prog_ctrl_chk #(
  .ROW_WORDS(ROW_WORDS), .ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .err       (err),
  .key_open  (key_open),
  .reg_wr    (reg_wr),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .arr_erase (arr_erase),
  .arr_prog  (arr_prog),
  .arr_wr    (arr_wr),
  .arr_row   (arr_row),
  .arr_col   (arr_col)
);

// File: tb/nvm_prog_ctrl_tb.sv
module nvm_prog_ctrl_tb;
  localparam int ROWN  = 8;
  localparam int COL_W = 3;
  localparam int ROW_W = 24 - COL_W;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] rd_data;
  logic tw_en = 1'b0, tw_hi = 1'b0;
  logic [23:0] tw_addr = '0;
  logic [15:0] tw_data = '0;
  logic busy, err, arr_erase, arr_prog, arr_wr;
  logic [ROW_W-1:0] arr_row;
  logic [COL_W-1:0] arr_col;
  logic [23:0] arr_wdata;
  logic arr_done = 1'b0;

  always #10 clk = ~clk;

  nvm_prog_ctrl #(.ROW_WORDS(ROWN)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .rd_data(rd_data), .tw_en(tw_en), .tw_hi(tw_hi),
    .tw_addr(tw_addr), .tw_data(tw_data), .busy(busy), .err(err),
    .arr_erase(arr_erase), .arr_prog(arr_prog), .arr_row(arr_row),
    .arr_wr(arr_wr), .arr_col(arr_col), .arr_wdata(arr_wdata),
    .arr_done(arr_done)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural flash array
  logic [23:0] flash [logic [23:0]];
  logic [23:0] pbuf [ROWN];
  int dcnt = 0, n_erase = 0, n_prog = 0;

  function automatic logic [23:0] fl(input logic [23:0] a);
    return flash.exists(a) ? flash[a] : 24'hFFFFFF;
  endfunction

  always @(negedge clk) begin
    arr_done <= 1'b0;
    if (dcnt > 0) begin
      dcnt--;
      if (dcnt == 0) arr_done <= 1'b1;
    end
    if (!rst) begin
      if (arr_wr) pbuf[arr_col] = arr_wdata;
      if (arr_erase) begin
        for (int c = 0; c < ROWN; c++) flash[{arr_row, COL_W'(c)}] = 24'hFFFFFF;
        n_erase++;
        dcnt = LAT;
      end
      if (arr_prog) begin
        for (int c = 0; c < ROWN; c++)
          flash[{arr_row, COL_W'(c)}] = fl({arr_row, COL_W'(c)}) & pbuf[c];
        n_prog++;
        dcnt = LAT;
      end
    end
  end

  // cycle reference model
  int m_key, m_fill, nk, nf, idx;
  bit m_busy, m_err, m_op, m_prog, m_lop, setf, clrf, nb, nl;
  logic [23:0] m_adr;
  logic [ROW_W-1:0] m_tag, rowv;
  logic [15:0] exp_rd;

  always @(posedge clk) begin
    if (rst) begin
      m_key = 0; m_fill = 0; m_busy = 0; m_err = 0; m_op = 0; m_prog = 0;
      m_lop = 0; m_adr = '0; m_tag = '0; exp_rd = '0;
    end else begin
      case (reg_sel)
        2'd0: exp_rd = {12'd0, (m_fill == ROWN), m_err, m_op, m_busy};
        2'd1: exp_rd = m_adr[15:0];
        2'd2: exp_rd = {8'd0, m_adr[23:16]};
        default: exp_rd = '0;
      endcase
      setf = 0; clrf = 0; nb = m_busy; nk = m_key; nf = m_fill; nl = m_lop;
      if (arr_done && m_busy) begin
        nb = 0;
        if (m_prog) begin nf = 0; nl = 0; end
      end
      if (tw_en) begin
        m_adr = tw_addr;
        if (m_key == 1) nk = 0;
        idx = int'(tw_addr % ROWN);
        rowv = tw_addr[23:COL_W];
        if (m_busy) setf = 1;
        else if (tw_hi) begin
          if (m_lop && m_fill < ROWN && idx == m_fill && rowv == m_tag) begin
            nf = m_fill + 1; nl = 0;
          end else setf = 1;
        end else begin
          if (m_fill < ROWN && idx == m_fill && (m_fill == 0 || rowv == m_tag)) begin
            nl = 1; m_tag = rowv;
          end else setf = 1;
        end
      end
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin
            if (m_key == 1) nk = 0;
            if (!m_busy) begin
              m_op = reg_wdata[1];
              if (reg_wdata[2]) clrf = 1;
              if (reg_wdata[0]) begin
                if (m_key == 2) begin nb = 1; m_prog = reg_wdata[1]; nk = 0; end
                else setf = 1;
              end
            end
          end
          2'd1: begin m_adr[15:0] = reg_wdata; if (m_key == 1) nk = 0; end
          2'd2: begin m_adr[23:16] = reg_wdata[7:0]; if (m_key == 1) nk = 0; end
          default: begin
            if (reg_wdata[7:0] == 8'h55) nk = 1;
            else if (reg_wdata[7:0] == 8'hAA && m_key == 1) nk = 2;
            else nk = 0;
          end
        endcase
      end
      m_err = setf ? 1'b1 : (clrf ? 1'b0 : m_err);
      m_busy = nb; m_key = nk; m_fill = nf; m_lop = nl;
    end
  end

  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(busy == m_busy, "R7 busy vs model", 32'(busy), 32'(m_busy));
      check(err == m_err, "R3 err vs model", 32'(err), 32'(m_err));
      check(rd_data == exp_rd, "R9 rd_data vs model", 32'(rd_data), 32'(exp_rd));
    end
  end

  task automatic reg_w(input logic [1:0] s, input logic [15:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic tw_w(input bit hi, input logic [23:0] a, input logic [15:0] d);
    tw_en = 1'b1; tw_hi = hi; tw_addr = a; tw_data = d;
    @(negedge clk);
    tw_en = 1'b0;
  endtask

  task automatic load_word(input logic [23:0] a, input logic [23:0] w);
    tw_w(1'b0, a, w[15:0]);
    tw_w(1'b1, a, {8'd0, w[23:16]});
  endtask

  task automatic unlock();
    reg_w(2'd3, 16'h0055);
    reg_w(2'd3, 16'h00AA);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
  endtask

  localparam logic [23:0] RA = 24'h012340;
  localparam logic [23:0] RB = 24'h0ABC08;
  logic [23:0] wa [ROWN];
  logic [23:0] wb [3];
  int e0;

  initial begin
    for (int c = 0; c < ROWN; c++) begin
      wa[c] = 24'hA50000 ^ (24'(c) * 24'h010203);
      flash[RA + 24'(c)] = 24'h000000;
    end
    for (int c = 0; c < 3; c++) wb[c] = 24'h3C0F00 + 24'(c);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); @(negedge clk);
    check(busy == 0, "R1 busy after reset", 32'(busy), 0);
    check(err == 0, "R1 err after reset", 32'(err), 0);
    check(rd_data == 0, "R1 ctrl read after reset", 32'(rd_data), 0);

    // R4 direct address writes
    reg_w(2'd1, 16'h1234); reg_w(2'd2, 16'h0056);
    reg_sel = 2'd1; @(negedge clk); @(negedge clk);
    check(rd_data == 16'h1234, "R4 low address", 32'(rd_data), 32'h1234);
    reg_sel = 2'd2; @(negedge clk); @(negedge clk);
    check(rd_data == 16'h0056, "R4 high address", 32'(rd_data), 32'h56);

    // R3 start without unlock
    reg_w(2'd0, 16'h0001);
    check(err == 1, "R3 err on locked start", 32'(err), 1);
    check(busy == 0 && n_erase == 0, "R3 no launch when locked", 32'(n_erase), 0);
    reg_w(2'd0, 16'h0004);
    check(err == 0, "R3 err cleared", 32'(err), 0);

    // R2 sequence broken by another write, then by a wrong value
    reg_w(2'd3, 16'h0055); reg_w(2'd1, 16'h0000); reg_w(2'd3, 16'h00AA);
    reg_w(2'd0, 16'h0001);
    check(err == 1 && busy == 0, "R2 interrupted key", 32'(err), 1);
    reg_w(2'd0, 16'h0004);
    reg_w(2'd3, 16'h0055); reg_w(2'd3, 16'h0012); reg_w(2'd3, 16'h00AA);
    reg_w(2'd0, 16'h0001);
    check(err == 1 && busy == 0, "R2 wrong key value", 32'(err), 1);
    reg_w(2'd0, 16'h0004);
    check(n_erase == 0, "R2 no erase from bad keys", 32'(n_erase), 0);

    // R7 erase row A
    reg_w(2'd1, RA[15:0]); reg_w(2'd2, {8'd0, RA[23:16]});
    unlock();
    reg_w(2'd0, 16'h0001);
    check(busy == 1, "R7 busy after erase start", 32'(busy), 1);
    wait_idle();
    check(n_erase == 1, "R7 one erase", 32'(n_erase), 1);
    for (int c = 0; c < ROWN; c++)
      check(fl(RA + 24'(c)) == 24'hFFFFFF, "R7 erased word", 32'(fl(RA + 24'(c))), 32'hFFFFFF);

    // R2 unlock used up
    reg_w(2'd0, 16'h0001);
    check(err == 1 && busy == 0, "R2 unlock consumed", 32'(busy), 0);
    reg_w(2'd0, 16'h0004);

    // R5 full row into row A
    for (int c = 0; c < ROWN; c++) load_word(RA + 24'(c), wa[c]);
    reg_sel = 2'd0; @(negedge clk); @(negedge clk);
    check(rd_data[3] == 1'b1, "R9 full flag", 32'(rd_data), 32'h8);
    tw_w(1'b0, RA, 16'h0000);
    check(err == 1, "R5 write into full buffer", 32'(err), 1);
    reg_w(2'd0, 16'h0004);

    // R8 program row A, with R6 and R10 during busy
    unlock();
    reg_w(2'd0, 16'h0003);
    check(busy == 1, "R8 busy after program start", 32'(busy), 1);
    tw_w(1'b0, RB, 16'h0000);
    check(err == 1, "R6 table write while busy", 32'(err), 1);
    reg_w(2'd0, 16'h0004);
    check(err == 1, "R10 clear ignored while busy", 32'(err), 1);
    wait_idle();
    reg_w(2'd0, 16'h0004);
    check(n_prog == 1, "R8 one program", 32'(n_prog), 1);
    for (int c = 0; c < ROWN; c++)
      check(fl(RA + 24'(c)) == wa[c], "R8 programmed word", 32'(fl(RA + 24'(c))), 32'(wa[c]));
    reg_sel = 2'd0; @(negedge clk); @(negedge clk);
    check(rd_data[3] == 1'b0, "R8 buffer empty after program", 32'(rd_data), 0);

    // R5 ordering rules on row B
    tw_w(1'b0, RB + 24'd1, 16'h1111);
    check(err == 1, "R5 unaligned first write", 32'(err), 1);
    reg_w(2'd0, 16'h0004);
    load_word(RB, wb[0]);
    tw_w(1'b0, RB + 24'd2, 16'h2222);
    check(err == 1, "R5 skipped column", 32'(err), 1);
    reg_w(2'd0, 16'h0004);
    load_word(RB + 24'd1, wb[1]);
    load_word(RB + 24'd2, wb[2]);
    tw_w(1'b1, RB + 24'd3, 16'h0077);
    check(err == 1, "R5 high without low", 32'(err), 1);
    reg_w(2'd0, 16'h0004);
    reg_sel = 2'd1; @(negedge clk); @(negedge clk);
    check(rd_data == RB[15:0] + 16'd3, "R4 captured table address", 32'(rd_data), 32'(RB[15:0] + 16'd3));

    // R8 partial row, R10 start while busy
    unlock();
    reg_w(2'd0, 16'h0003);
    unlock();
    reg_w(2'd0, 16'h0001);
    check(busy == 1 && err == 0, "R10 start while busy ignored", 32'(err), 0);
    wait_idle();
    for (int c = 0; c < ROWN; c++) begin
      logic [23:0] ev;
      ev = (c < 3) ? wb[c] : 24'hFFFFFF;
      check(fl(RB + 24'(c)) == ev, "R8 partial row word", 32'(fl(RB + 24'(c))), 32'(ev));
    end
    e0 = n_erase;
    reg_w(2'd0, 16'h0001);
    check(busy == 1, "R10 unlock kept across busy", 32'(busy), 1);
    wait_idle();
    check(n_erase == e0 + 1, "R7 erase of row B", 32'(n_erase), 32'(e0 + 1));
    check(fl(RB) == 24'hFFFFFF, "R7 row B erased", 32'(fl(RB)), 32'hFFFFFF);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule